// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a virtual page into a real page by searching a hashed page table. The table sits in an external memory with 32-bit words. The caller presents a segment identifier, an effective address, a load/store flag, and the table base and mask, then pulses `start`. The engine forms a 19-bit hash from the segment identifier and the page index. It reads the eight two-word entries of the group that hash selects and compares each one against the request. If no entry in that group matches, it repeats the search in a second group selected by the bitwise complement of the hash.

On a hit, the engine sets the referenced flag in the entry's second word, and also the changed flag when the access is a store. It writes that word back only if its value has changed. It then returns the real address and the entry's two-bit page-protection field. It also returns a write-allowed flag. This flag stays clear for a load that finds the changed flag clear, so a later store has to walk the table again and mark the page as modified. If both groups fail, a not-found flag is returned instead.

The memory port is synchronous. A read issued in one cycle returns its data on `mem_rdata` in the next cycle.

Top module: `hpt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done`, `busy`, `mem_rd` and `mem_wr` are 0.
- R2: The hash is `vsid[18:0]` XOR the zero-extended page index `eaddr[27:12]`. The group byte address is `tbl_base` OR ((hash × 64) AND `tbl_mask`). Entry i of a group occupies word addresses group/4 + 2i (first word) and group/4 + 2i + 1 (second word). The memory returns read data one cycle after `mem_rd`.
- R3: A first word matches only if bit 31 (valid) is 1, bit 6 (group select) equals the current pass (0 for the first pass, 1 for the second), bits 30:7 equal `vsid`, and bits 5:0 equal `eaddr[27:22]`.
- R4: If the first group has no match, the group at the complemented hash is searched with select 1. If that also fails, `not_found` is 1 and no memory write occurs. `done` is then seen on the 33rd rising edge, counting the edge that accepted `start` as the first.
- R5: Entries are examined in ascending order, and the first match ends the search. Later matches are never read.
- R6: On a hit, the written second word has bit 8 (referenced) set. For a store, bit 7 (changed) is also set. All other bits are kept.
- R7: The second word is written back, at its own address, only when its value changes. `done` follows the write in the next cycle.
- R8: `wr_ok` is 1 after a store hit. After a load hit, `wr_ok` equals the changed bit the entry held before the walk.
- R9: On a hit, `real_addr` is {second word bits 31:12, `eaddr[11:0]`} and `pp` is second word bits 1:0.
- R10: `done` is a one-cycle pulse on rising edge 2n+4+w, where n is the number of entries examined before the match and w is 1 if a write-back occurs. `start` is ignored while `busy` is 1, so results are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| vsid | input | 24 | Segment identifier |
| eaddr | input | 32 | Effective address |
| is_store | input | 1 | 1 for a store access |
| tbl_base | input | 32 | Table byte base address |
| tbl_mask | input | 32 | Group-offset mask |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| not_found | output | 1 | No matching entry in either group |
| real_addr | output | 32 | Translated real address |
| pp | output | 2 | Protection field of matched entry |
| wr_ok | output | 1 | Write permission granted |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data (one cycle after read) |

## Verification
The hardest case to reach is a hit in the second group behind a first group full of near-misses. One of those near-misses carries the correct tag with the select bit set, so it must be rejected on the first pass. The bench builds such groups directly in its memory model. Each decoy differs from the request in exactly one field: valid, select, segment identifier or abbreviated page index. The bench also pulses `start` with a different request in the middle of a walk. It then checks that the completion cycle and the results belong to the first request.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int VSID_W    = 24;
  localparam int API_W     = 6;
  localparam int WORD_W    = 32;
  // first-word layout
  localparam int W0_SEL    = API_W;
  localparam int W0_VSIDLO = API_W + 1;
  localparam int W0_VALID  = W0_VSIDLO + VSID_W;
  // second-word layout
  localparam int W1_REF    = 8;
  localparam int W1_CHG    = 7;
  localparam int PG_BITS   = 12;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD0  = 3'd1,
    ST_CMP  = 3'd2,
    ST_UPD  = 3'd3,
    ST_WB   = 3'd4,
    ST_FIN  = 3'd5
  } walk_st_e;
endpackage

// File: rtl/hpt_group_addr.sv
module hpt_group_addr #(
  parameter int AW      = 32,
  parameter int HASH_W  = 19,
  parameter int PIDX_W  = 16,
  parameter int GRP_LSB = 6
) (
  input  logic [hpt_pkg::VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0]          pidx,
  input  logic                       second,
  input  logic [AW-1:0]              base,
  input  logic [AW-1:0]              mask,
  output logic [AW-1:0]              grp_addr
);
  logic [HASH_W-1:0] h1, hsel;
  logic [AW-1:0]     hx;

  always_comb begin
    h1       = vsid[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, pidx};
    hsel     = second ? ~h1 : h1;
    hx       = {{(AW-HASH_W){1'b0}}, hsel} << GRP_LSB;
    grp_addr = base | (hx & mask);
  end
endmodule

// File: rtl/hpt_tag_cmp.sv
module hpt_tag_cmp (
  input  logic [hpt_pkg::WORD_W-1:0] w0,
  input  logic [hpt_pkg::VSID_W-1:0] vsid,
  input  logic [hpt_pkg::API_W-1:0]  api,
  input  logic                       pass,
  output logic                       hit
);
  import hpt_pkg::*;
  logic vld, sel_ok, vs_ok, api_ok;

  always_comb begin
    vld    = w0[W0_VALID];
    sel_ok = (w0[W0_SEL] == pass);
    vs_ok  = (w0[W0_VALID-1:W0_VSIDLO] == vsid);
    api_ok = (w0[API_W-1:0] == api);
    hit    = vld & sel_ok & vs_ok & api_ok;
  end
endmodule

// File: rtl/hpt_refchg.sv
module hpt_refchg (
  input  logic [hpt_pkg::WORD_W-1:0] w1_old,
  input  logic                       store,
  output logic [hpt_pkg::WORD_W-1:0] w1_new,
  output logic                       need_wb,
  output logic                       wr_perm
);
  import hpt_pkg::*;

  always_comb begin
    w1_new         = w1_old;
    w1_new[W1_REF] = 1'b1;
    if (store) w1_new[W1_CHG] = 1'b1;
    need_wb        = (w1_new != w1_old);
    // loads on a clean page get read-only so the first store walks again
    wr_perm        = store | w1_old[W1_CHG];
  end

  always_comb begin
    if (need_wb) assert (w1_new[W1_REF]) else $error("p_wb_sets_ref_r6");
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int AW          = 32,
  parameter int HASH_W      = 19,
  parameter int GRP_ENTRIES = 8,
  parameter int ENT_BYTES   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [hpt_pkg::VSID_W-1:0] vsid,
  input  logic [AW-1:0]              eaddr,
  input  logic                       is_store,
  input  logic [AW-1:0]              tbl_base,
  input  logic [AW-1:0]              tbl_mask,
  output logic                       busy,
  output logic                       done,
  output logic                       not_found,
  output logic [AW-1:0]              real_addr,
  output logic [1:0]                 pp,
  output logic                       wr_ok,
  output logic                       mem_rd,
  output logic                       mem_wr,
  output logic [AW-3:0]              mem_addr,
  output logic [hpt_pkg::WORD_W-1:0] mem_wdata,
  input  logic [hpt_pkg::WORD_W-1:0] mem_rdata
);
  import hpt_pkg::*;

  localparam int IDX_W   = $clog2(GRP_ENTRIES);
  localparam int GRP_LSB = $clog2(GRP_ENTRIES * ENT_BYTES);
  localparam int WA_W    = AW - 2;
  localparam int PIDX_W  = 28 - PG_BITS;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRP_ENTRIES - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  walk_st_e              st_q, st_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic                  pass_q, pass_d;
  logic [VSID_W-1:0]     vsid_q;
  logic [AW-1:0]         ea_q, base_q, mask_q;
  logic                  store_q;
  logic                  nf_q, nf_d;
  logic [AW-1:0]         ra_q;
  logic [1:0]            pp_q;
  logic                  wok_q;
  logic [WORD_W-1:0]     w1n_q;
  logic                  req_en, res_en;

  logic [AW-1:0]         grp_addr;
  logic                  tag_hit;
  logic [WORD_W-1:0]     w1_new;
  logic                  need_wb, wr_perm;

  hpt_group_addr #(
    .AW(AW), .HASH_W(HASH_W), .PIDX_W(PIDX_W), .GRP_LSB(GRP_LSB)
  ) u_gaddr (
    .vsid    (vsid_q),
    .pidx    (ea_q[PG_BITS+PIDX_W-1:PG_BITS]),
    .second  (pass_q),
    .base    (base_q),
    .mask    (mask_q),
    .grp_addr(grp_addr)
  );

  hpt_tag_cmp u_tag (
    .w0  (mem_rdata),
    .vsid(vsid_q),
    .api (ea_q[PG_BITS+PIDX_W-1:PG_BITS+PIDX_W-API_W]),
    .pass(pass_q),
    .hit (tag_hit)
  );

  hpt_refchg u_rc (
    .w1_old (mem_rdata),
    .store  (store_q),
    .w1_new (w1_new),
    .need_wb(need_wb),
    .wr_perm(wr_perm)
  );

  // next-state
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    pass_d = pass_q;
    nf_d   = nf_q;
    req_en = 1'b0;
    res_en = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        req_en = 1'b1;
        idx_d  = '0;
        pass_d = 1'b0;
        nf_d   = 1'b0;
        st_d   = ST_RD0;
      end
      ST_RD0: st_d = ST_CMP;
      ST_CMP: begin
        if (tag_hit) begin
          st_d = ST_UPD;
        end else if (idx_q != LAST_IDX) begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_RD0;
        end else if (!pass_q) begin
          idx_d  = '0;
          pass_d = 1'b1;
          st_d   = ST_RD0;
        end else begin
          nf_d = 1'b1;
          st_d = ST_FIN;
        end
      end
      ST_UPD: begin
        res_en = 1'b1;
        st_d   = need_wb ? ST_WB : ST_FIN;
      end
      ST_WB:   st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      pass_q <= 1'b0;
      nf_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      pass_q <= pass_d;
      nf_q   <= nf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vsid_q  <= '0;
      ea_q    <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      store_q <= 1'b0;
    end else if (req_en) begin
      vsid_q  <= vsid;
      ea_q    <= eaddr;
      base_q  <= tbl_base;
      mask_q  <= tbl_mask;
      store_q <= is_store;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ra_q  <= '0;
      pp_q  <= '0;
      wok_q <= 1'b0;
      w1n_q <= '0;
    end else if (res_en) begin
      ra_q  <= {mem_rdata[AW-1:PG_BITS], ea_q[PG_BITS-1:0]};
      pp_q  <= mem_rdata[1:0];
      wok_q <= wr_perm;
      w1n_q <= w1_new;
    end
  end

  // memory port
  logic [WA_W-1:0] grp_word;
  logic            odd_word;
  always_comb begin
    grp_word  = grp_addr[AW-1:2];
    odd_word  = (st_q != ST_RD0);
    mem_addr  = grp_word + {{(WA_W-IDX_W-1){1'b0}}, idx_q, odd_word};
    mem_rd    = (st_q == ST_RD0) || (st_q == ST_CMP && tag_hit);
    mem_wr    = (st_q == ST_WB);
    mem_wdata = w1n_q;
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign not_found = nf_q;
  assign real_addr = ra_q;
  assign pp        = pp_q;
  assign wr_ok     = wok_q;

  // assertions
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);
  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    !(mem_rd && mem_wr));
  p_wb_then_done_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_wr |=> done);
  p_wb_has_ref_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_wr |-> mem_wdata[W1_REF]);
  p_miss_no_write_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && not_found) |-> !$past(mem_wr));
  p_store_wok_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && !not_found && store_q) |-> wr_ok);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && start) |=> $stable(vsid_q) && $stable(ea_q));
endmodule

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] vsid = '0;
  logic [31:0] eaddr = '0;
  logic        is_store = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [31:0] tbl_mask = 32'h0000_3FC0;
  logic        busy, done, not_found, wr_ok, mem_rd, mem_wr;
  logic [31:0] real_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  pp;
  logic [29:0] mem_addr;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [31:0] mem [0:4095];

  always #2 clk = ~clk;

  hpt_walker u_hpt_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .vsid(vsid), .eaddr(eaddr),
    .is_store(is_store), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
    .busy(busy), .done(done), .not_found(not_found), .real_addr(real_addr),
    .pp(pp), .wr_ok(wr_ok), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w0(input bit v, input logic [23:0] vs,
                                        input bit sel, input logic [5:0] api);
    return {v, vs, sel, api};
  endfunction

  function automatic int grp_word(input logic [23:0] vs, input logic [31:0] ea, input bit sec);
    logic [18:0] h;
    logic [31:0] off;
    h = vs[18:0] ^ {3'b000, ea[27:12]};
    if (sec) h = ~h;
    off = ({13'd0, h} * 32'd64) & tbl_mask;
    return int'((tbl_base | off) >> 2) & 4095;
  endfunction

  task automatic put(input int gw, input int i, input logic [31:0] w0, input logic [31:0] w1);
    mem[gw + 2*i]     = w0;
    mem[gw + 2*i + 1] = w1;
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 4096; k++) mem[k] = '0;
  endtask

  // behavioural model and one walk
  task automatic walk(input string tag, input logic [23:0] v, input logic [31:0] ea,
                      input bit st, input int poke_at);
    bit hit = 0;
    int n = 0, w1a = 0, cnt, wr0, exp_cnt;
    logic [31:0] w0, w1o, w1n;
    bit wb;
    for (int p = 0; p < 2 && !hit; p++) begin
      for (int i = 0; i < 8 && !hit; i++) begin
        w0 = mem[grp_word(v, ea, p[0]) + 2*i];
        if (w0[31] && w0[6] == p[0] && w0[30:7] == v && w0[5:0] == ea[27:22]) begin
          hit = 1;
          w1a = grp_word(v, ea, p[0]) + 2*i + 1;
        end else n++;
      end
    end
    w1o = hit ? mem[w1a] : '0;
    w1n = w1o | 32'h100 | (st ? 32'h80 : 32'h0);
    wb  = hit && (w1n != w1o);
    exp_cnt = hit ? 2*n + 4 + int'(wb) : 33;
    wr0 = wr_cnt;

    @(negedge clk);
    vsid = v; eaddr = ea; is_store = st; start = 1'b1;
    @(posedge clk);
    cnt = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt < 100) begin
      if (cnt == poke_at) begin
        start = 1'b1; vsid = ~v; eaddr = ~ea; is_store = ~st;
      end else start = 1'b0;
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    start = 1'b0;
    chk({tag, " R10 done cycle"}, cnt, exp_cnt);
    chk({tag, " R4 not_found"}, {31'd0, not_found}, {31'd0, !hit});
    if (hit) begin
      chk({tag, " R9 real_addr"}, real_addr, {w1o[31:12], ea[11:0]});
      chk({tag, " R9 pp"}, {30'd0, pp}, {30'd0, w1o[1:0]});
      chk({tag, " R8 wr_ok"}, {31'd0, wr_ok}, {31'd0, st | w1o[7]});
      chk({tag, " R6 second word"}, mem[w1a], w1n);
    end
    chk({tag, " R7 write count"}, wr_cnt - wr0, wb ? 1 : 0);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R10 done pulse"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    int g;
    logic [23:0] v;
    logic [31:0] ea;
    clear_mem();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done in reset", {31'd0, done}, 0);
    chk("R1 mem_rd/mem_wr in reset", {30'd0, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 busy after release", {31'd0, busy}, 0);
    chk("R1 done after release", {31'd0, done}, 0);
    repeat (2) @(posedge clk);

    // R2/R3: load hit at entry 0, clean page -> R set, read-only
    v = 24'h123456; ea = 32'h5ABC_D123;
    g = grp_word(v, ea, 0);
    put(g, 0, mk_w0(1, v, 0, ea[27:22]), 32'hCAFE_1002);
    walk("t1 load entry0 R2 R3", v, ea, 0, 0);
    // store on same page: changed bit set, write-back
    walk("t2 store lazy change R6", v, ea, 1, 0);
    // load again: both flags set, no write
    walk("t3 load clean R7", v, ea, 0, 0);

    // R3/R5: decoys then match at entry 5
    clear_mem();
    v = 24'hA5A5A5; ea = 32'h3C21_4777;
    g = grp_word(v, ea, 0);
    put(g, 0, mk_w0(0, v, 0, ea[27:22]), 32'h1111_1000);
    put(g, 1, mk_w0(1, v, 1, ea[27:22]), 32'h2222_2000);
    put(g, 2, mk_w0(1, v ^ 24'h1, 0, ea[27:22]), 32'h3333_3000);
    put(g, 3, mk_w0(1, v, 0, ea[27:22] ^ 6'h20), 32'h4444_4000);
    put(g, 5, mk_w0(1, v, 0, ea[27:22]), 32'h5555_5181);
    walk("t4 store entry5 R3 R6", v, ea, 1, 0);

    // R4: secondary hit behind full primary of near-misses
    clear_mem();
    v = 24'h0F0F0F; ea = 32'h9876_5ABC;
    g = grp_word(v, ea, 0);
    for (int i = 0; i < 8; i++) put(g, i, mk_w0(1, v, 1, ea[27:22]), 32'hDEAD_0003);
    g = grp_word(v, ea, 1);
    put(g, 1, mk_w0(1, v, 0, ea[27:22]), 32'h7777_7000);
    put(g, 3, mk_w0(1, v, 1, ea[27:22]), 32'h8888_8101);
    walk("t5 secondary hit R4", v, ea, 0, 0);

    // R4: miss in both groups
    g = grp_word(v, ea, 1);
    put(g, 3, mk_w0(0, v, 1, ea[27:22]), 32'h8888_8101);
    walk("t6 miss R4", v, ea, 1, 0);

    // R5: two matches, first wins
    clear_mem();
    v = 24'h00BEEF; ea = 32'h0123_4567;
    g = grp_word(v, ea, 0);
    put(g, 2, mk_w0(1, v, 0, ea[27:22]), 32'hAAAA_A002);
    put(g, 6, mk_w0(1, v, 0, ea[27:22]), 32'hBBBB_B001);
    walk("t7 first match R5", v, ea, 0, 0);
    chk("t7 R5 later entry untouched", mem[g + 13], 32'hBBBB_B001);

    // R2 narrow mask, R10 start while busy
    clear_mem();
    tbl_mask = 32'h0000_0FC0;
    tbl_base = 32'h0000_2000;
    v = 24'h3210FE; ea = 32'hF00D_B0A5;
    g = grp_word(v, ea, 0);
    put(g, 4, mk_w0(1, v, 0, ea[27:22]), 32'h0ABC_D180);
    walk("t8 mask base busy-start R2 R10", v, ea, 0, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule